// File: doc/BRIEF.md
# Packed Single-Precision Multiplier

This block multiplies two packed vectors of IEEE-754 single-precision numbers, lane by lane. With the default parameters each 64-bit source holds two independent 32-bit numbers. Every clock can accept a new pair of sources, so the block delivers two products per cycle. Each result leaves the pipeline a fixed number of cycles after its request, and it carries the tag the requester gave it.

Each request carries its own rounding-mode field and flush-to-zero enable. Normal numbers, zeros, infinities and NaNs are handled fully. A result too small to be a normal number is replaced by a signed zero and raised as an underflow; the block never produces a denormal. Denormal operands are read as zero, and the flush-to-zero enable decides whether that is reported. Each lane returns four status bits that a surrounding control register can mask.

Top module: `pkmul_top`

## Requirements
- R1: Lane L occupies bits [32L+31:32L] of `in_a`, `in_b` and `out_res`, and each lane's result depends only on its own operand slices.
- R2: A request is accepted on every rising edge where `in_valid` is high, back-to-back, with no stall.
- R3: A request sampled at a rising edge produces `out_valid` high for exactly one cycle, starting at the third rising edge after that one. `out_valid` is low in every other cycle.
- R4: `out_tag` equals the `in_tag` of the request whose result is shown.
- R5: Finite nonzero products are rounded to 24 significant bits using `in_rmode`: 00 = nearest-even, 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero. A rounded product sets the inexact flag.
- R6: On overflow the result is infinity in nearest-even mode, in the mode toward that sign's infinity, or both. In the other modes it is the largest finite value 0x7F7FFFFF with the sign applied. Overflow and inexact are both set.
- R7: A product whose rounded exponent falls below the normal range becomes a signed zero with underflow and inexact set. No output ever has a zero exponent with a nonzero fraction.
- R8: A denormal operand is read as zero. With `in_ftz` = 1 no flag is raised. With `in_ftz` = 0 a resulting zero product raises underflow.
- R9: A NaN operand is returned with fraction bit 22 set; operand a wins if both are NaN. Invalid is set only if a NaN operand had bit 22 clear. Zero times infinity gives 0xFFC00000 with invalid set.
- R10: For every non-NaN result, including zeros and infinities, the sign is the XOR of the operand signs.
- R11: `out_flags` holds 4 bits per lane, lane L at [4L+3:4L], ordered {invalid, overflow, underflow, inexact} from bit 3 down to bit 0.
- R12: While reset is held, and after it is released until the first result, `out_valid`, `out_res` and `out_flags` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_a | input | 32*LANES | First packed source |
| in_b | input | 32*LANES | Second packed source |
| in_ftz | input | 1 | Flush-to-zero enable for this request |
| in_rmode | input | 2 | Rounding mode for this request |
| in_tag | input | TAG_W | Requester tag |
| out_valid | output | 1 | Result strobe |
| out_res | output | 32*LANES | Packed products |
| out_tag | output | TAG_W | Echoed tag |
| out_flags | output | 4*LANES | Per-lane status flags |

## Verification
The bench builds the block with its defaults: two lanes and a 4-bit tag. Two lanes let every request pair a positive case with a negative or special case, which puts lane independence and the sign rule in view at once. The 4-bit tag wraps several times during the long back-to-back bursts, while four requests are still in flight. This shows the tag needs to cover only the pipeline depth. All four rounding modes are applied to a halfway case and to an overflow case, in both lanes with opposite signs.

// File: rtl/pkmul_pkg.sv
// Shared constants and types for the packed single-precision multiplier.
// Assumes binary32 operands; the pipeline depth is fixed by the datapath split.
package pkmul_pkg;
    localparam int SP_W       = 32;
    localparam int EXP_W      = 8;
    localparam int FRAC_W     = 23;
    localparam int MANT_W     = FRAC_W + 1;
    localparam int PROD_W     = 2 * MANT_W;
    localparam int FLAG_W     = 4;
    localparam int PIPE_DEPTH = 4;
    localparam int EXP_BIAS   = 127;

    localparam logic [SP_W-1:0] QNAN_DEFAULT = 32'hFFC0_0000;

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_ZERO = 2'b11
    } rnd_mode_e;

    typedef struct packed {
        logic inv;
        logic ovf;
        logic unf;
        logic inx;
    } sp_flags_t;
endpackage

// File: rtl/pkmul_ctl.sv
// Control pipeline: carries the valid strobe and the tag alongside the lanes.
// Assumes the lanes have exactly PIPE_DEPTH register stages and no stall.
module pkmul_ctl
    import pkmul_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag
);
    logic [PIPE_DEPTH-1:0] vld_q;
    logic [TAG_W-1:0]      tag_q [PIPE_DEPTH];

    // Shift valid and tag one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < PIPE_DEPTH; i++) tag_q[i] <= '0;
        end else begin
            vld_q    <= {vld_q[PIPE_DEPTH-2:0], in_valid};
            tag_q[0] <= in_tag;
            for (int i = 1; i < PIPE_DEPTH; i++) tag_q[i] <= tag_q[i-1];
        end
    end

    assign out_valid = vld_q[PIPE_DEPTH-1];
    assign out_tag   = tag_q[PIPE_DEPTH-1];

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 4));
    assert_tag_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_tag == $past(in_tag, 4)));
endmodule

// File: rtl/pkmul_lane.sv
// One binary32 multiplier lane in four register stages:
// decode, significand product, normalise, round and pack.
// Assumes no stall; every stage loads on every clock.
// Denormal results are never produced.
module pkmul_lane
    import pkmul_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SP_W-1:0] a,
    input  logic [SP_W-1:0] b,
    input  logic            ftz,
    input  logic [1:0]      rmode,
    output logic [SP_W-1:0] res,
    output sp_flags_t       flags
);
    localparam logic [EXP_W-1:0] EXP_MAX = '1;
    localparam logic [SP_W-1:0]  QBIT    = 32'h0040_0000;

    // ---------------- stage 1: decode ----------------
    logic [EXP_W-1:0]  ea, eb;
    logic [FRAC_W-1:0] fa, fb;
    logic a_zero, b_zero, a_sub, b_sub, a_inf, b_inf, a_nan, b_nan;
    logic              sgn_d, spec_d;
    logic [SP_W-1:0]   sres_d;
    sp_flags_t         sflg_d;
    logic signed [9:0] esum_d;

    assign ea = a[30:23];
    assign eb = b[30:23];
    assign fa = a[22:0];
    assign fb = b[22:0];
    assign a_sub  = (ea == '0) && (fa != '0);
    assign b_sub  = (eb == '0) && (fb != '0);
    assign a_zero = (ea == '0);
    assign b_zero = (eb == '0);
    assign a_inf  = (ea == EXP_MAX) && (fa == '0);
    assign b_inf  = (eb == EXP_MAX) && (fb == '0);
    assign a_nan  = (ea == EXP_MAX) && (fa != '0);
    assign b_nan  = (eb == EXP_MAX) && (fb != '0);
    assign sgn_d  = a[31] ^ b[31];
    assign esum_d = $signed({2'b00, ea}) + $signed({2'b00, eb}) - 10'sd127;

    // Resolve operand classes that bypass the arithmetic path.
    always_comb begin
        spec_d = 1'b1;
        sres_d = '0;
        sflg_d = '0;
        if (a_nan || b_nan) begin
            sres_d     = a_nan ? (a | QBIT) : (b | QBIT);
            sflg_d.inv = (a_nan && !fa[22]) || (b_nan && !fb[22]);
        end else if ((a_inf && b_zero) || (b_inf && a_zero)) begin
            sres_d     = QNAN_DEFAULT;
            sflg_d.inv = 1'b1;
        end else if (a_inf || b_inf) begin
            sres_d = {sgn_d, EXP_MAX, {FRAC_W{1'b0}}};
        end else if (a_zero || b_zero) begin
            sres_d     = {sgn_d, {(SP_W-1){1'b0}}};
            sflg_d.unf = !ftz && (a_sub || b_sub);
        end else begin
            spec_d = 1'b0;
        end
    end

    logic              s1_spec, s1_sgn;
    logic [SP_W-1:0]   s1_sres;
    sp_flags_t         s1_sflg;
    logic signed [9:0] s1_esum;
    logic [MANT_W-1:0] s1_ma, s1_mb;
    logic [1:0]        s1_rm;

    // Register decoded operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_spec <= 1'b0; s1_sgn <= 1'b0; s1_sres <= '0; s1_sflg <= '0;
            s1_esum <= '0; s1_ma <= '0; s1_mb <= '0; s1_rm <= '0;
        end else begin
            s1_spec <= spec_d; s1_sgn <= sgn_d; s1_sres <= sres_d; s1_sflg <= sflg_d;
            s1_esum <= esum_d; s1_ma <= {1'b1, fa}; s1_mb <= {1'b1, fb}; s1_rm <= rmode;
        end
    end

    // ---------------- stage 2: significand product ----------------
    logic              s2_spec, s2_sgn;
    logic [SP_W-1:0]   s2_sres;
    sp_flags_t         s2_sflg;
    logic signed [9:0] s2_esum;
    logic [PROD_W-1:0] s2_prod;
    logic [1:0]        s2_rm;

    // Form the full 48-bit product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_spec <= 1'b0; s2_sgn <= 1'b0; s2_sres <= '0; s2_sflg <= '0;
            s2_esum <= '0; s2_prod <= '0; s2_rm <= '0;
        end else begin
            s2_spec <= s1_spec; s2_sgn <= s1_sgn; s2_sres <= s1_sres; s2_sflg <= s1_sflg;
            s2_esum <= s1_esum; s2_prod <= s1_ma * s1_mb; s2_rm <= s1_rm;
        end
    end

    // ---------------- stage 3: normalise ----------------
    logic              s3_spec, s3_sgn, s3_grd, s3_stk;
    logic [SP_W-1:0]   s3_sres;
    sp_flags_t         s3_sflg;
    logic signed [9:0] s3_exp;
    logic [FRAC_W-1:0] s3_frac;
    logic [1:0]        s3_rm;

    // Select the leading one and split off guard and sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_spec <= 1'b0; s3_sgn <= 1'b0; s3_grd <= 1'b0; s3_stk <= 1'b0;
            s3_sres <= '0; s3_sflg <= '0; s3_exp <= '0; s3_frac <= '0; s3_rm <= '0;
        end else begin
            s3_spec <= s2_spec; s3_sgn <= s2_sgn; s3_sres <= s2_sres;
            s3_sflg <= s2_sflg; s3_rm <= s2_rm;
            if (s2_prod[PROD_W-1]) begin
                s3_frac <= s2_prod[46:24];
                s3_grd  <= s2_prod[23];
                s3_stk  <= |s2_prod[22:0];
                s3_exp  <= s2_esum + 10'sd1;
            end else begin
                s3_frac <= s2_prod[45:23];
                s3_grd  <= s2_prod[22];
                s3_stk  <= |s2_prod[21:0];
                s3_exp  <= s2_esum;
            end
        end
    end

    // ---------------- stage 4: round and pack ----------------
    rnd_mode_e         rm;
    logic              inc, lost, to_inf;
    logic [MANT_W:0]   mant_r;
    logic signed [9:0] exp_r;
    logic [SP_W-1:0]   res_d;
    sp_flags_t         flg_d;

    assign rm   = rnd_mode_e'(s3_rm);
    assign lost = s3_grd || s3_stk;

    // Decide the rounding increment for the selected mode.
    always_comb begin
        unique case (rm)
            RND_NEAR: inc = s3_grd && (s3_stk || s3_frac[0]);
            RND_DOWN: inc = lost && s3_sgn;
            RND_UP:   inc = lost && !s3_sgn;
            default:  inc = 1'b0;
        endcase
        to_inf = (rm == RND_NEAR) || (rm == RND_DOWN && s3_sgn) || (rm == RND_UP && !s3_sgn);
    end

    assign mant_r = {2'b01, s3_frac} + {{MANT_W{1'b0}}, inc};
    assign exp_r  = mant_r[MANT_W] ? s3_exp + 10'sd1 : s3_exp;

    // Range-check the rounded value and build result and flags.
    always_comb begin
        res_d = '0;
        flg_d = '0;
        if (s3_spec) begin
            res_d = s3_sres;
            flg_d = s3_sflg;
        end else if (exp_r > 10'sd254) begin
            res_d = to_inf ? {s3_sgn, EXP_MAX, {FRAC_W{1'b0}}}
                           : {s3_sgn, EXP_MAX - 8'd1, {FRAC_W{1'b1}}};
            flg_d.ovf = 1'b1;
            flg_d.inx = 1'b1;
        end else if (exp_r < 10'sd1) begin
            res_d     = {s3_sgn, {(SP_W-1){1'b0}}};
            flg_d.unf = 1'b1;
            flg_d.inx = 1'b1;
        end else begin
            res_d     = {s3_sgn, exp_r[EXP_W-1:0], mant_r[FRAC_W-1:0]};
            flg_d.inx = lost;
        end
    end

    // Register the packed result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res   <= '0;
            flags <= '0;
        end else begin
            res   <= res_d;
            flags <= flg_d;
        end
    end

    assert_invalid_qnan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flags.inv |-> (res[30:23] == EXP_MAX && res[22]));
    assert_no_denormal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res[30:23] == '0) |-> (res[22:0] == '0));
    assert_underflow_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.unf && !flags.inv) |-> (res[30:0] == '0));
    assert_overflow_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flags.ovf |-> (flags.inx && res[30:24] == 7'h7F));
endmodule

// File: rtl/pkmul_top.sv
// Packed binary32 multiplier: LANES independent lanes plus a matching
// control pipe for valid and tag. Assumes a request can enter every cycle.
module pkmul_top
    import pkmul_pkg::*;
#(
    parameter int LANES = 2,
    parameter int TAG_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [SP_W*LANES-1:0]   in_a,
    input  logic [SP_W*LANES-1:0]   in_b,
    input  logic                    in_ftz,
    input  logic [1:0]              in_rmode,
    input  logic [TAG_W-1:0]        in_tag,
    output logic                    out_valid,
    output logic [SP_W*LANES-1:0]   out_res,
    output logic [TAG_W-1:0]        out_tag,
    output logic [FLAG_W*LANES-1:0] out_flags
);
    pkmul_ctl #(.TAG_W(TAG_W)) i_ctl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .out_valid(out_valid), .out_tag(out_tag)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sp_flags_t lane_flags;
        pkmul_lane i_lane (
            .clk(clk), .rst_n(rst_n),
            .a(in_a[SP_W*l +: SP_W]), .b(in_b[SP_W*l +: SP_W]),
            .ftz(in_ftz), .rmode(in_rmode),
            .res(out_res[SP_W*l +: SP_W]), .flags(lane_flags)
        );
        assign out_flags[FLAG_W*l +: FLAG_W] = lane_flags;
    end
endmodule

// File: tb/test_pkmul_top.sv
// Scoreboard bench: the driver queues expected results, the monitor compares them.
module test_pkmul_top;
    localparam int LANES = 2;
    localparam int TAG_W = 4;
    localparam logic [3:0] F_INV = 4'b1000, F_OVF = 4'b0100, F_UNF = 4'b0010, F_INX = 4'b0001;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_ftz = 1'b0;
    logic [63:0] in_a = '0, in_b = '0;
    logic [1:0] in_rmode = '0;
    logic [TAG_W-1:0] in_tag = '0;
    logic out_valid;
    logic [63:0] out_res;
    logic [TAG_W-1:0] out_tag;
    logic [7:0] out_flags;

    pkmul_top #(.LANES(LANES), .TAG_W(TAG_W)) i_pkmul_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_ftz(in_ftz), .in_rmode(in_rmode), .in_tag(in_tag),
        .out_valid(out_valid), .out_res(out_res), .out_tag(out_tag), .out_flags(out_flags)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [63:0] res;
        logic [7:0] flg;
        logic [TAG_W-1:0] tag;
        int issue;
        string req;
    } exp_t;

    exp_t q[$];
    int cyc = 0, total = 0, bad = 0;
    logic [TAG_W-1:0] next_tag = '0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic send(input logic [63:0] a, input logic [63:0] b, input logic ftz,
                        input logic [1:0] rm, input logic [63:0] er, input logic [7:0] ef,
                        input string req);
        exp_t e;
        in_valid = 1'b1; in_a = a; in_b = b; in_ftz = ftz; in_rmode = rm; in_tag = next_tag;
        e.res = er; e.flg = ef; e.tag = next_tag; e.issue = cyc + 1; e.req = req;
        q.push_back(e);
        next_tag = next_tag + 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: compare each result with the oldest queued expectation (R3 R4 R11).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R3 unexpected out_valid", {63'b0, out_valid}, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(out_res === e.res, {e.req, " result"}, out_res, e.res);
                check(out_flags === e.flg, {e.req, " R11 flags"}, {56'b0, out_flags}, {56'b0, e.flg});
                check(out_tag === e.tag, "R4 tag echo", {60'b0, out_tag}, {60'b0, e.tag});
                check(cyc == e.issue + 3, "R3 latency", 64'(cyc - e.issue), 64'd3);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_res == '0 && out_flags == '0, "R12 reset state",
              {out_res[62:0], out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_res == '0, "R12 after release", {out_res[62:0], out_valid}, 64'd0);

        // R1 R2 R10: basic products, back-to-back
        send({32'h40000000, 32'hC0000000}, {32'h40400000, 32'h40400000}, 0, 2'b00,
             {32'h40C00000, 32'hC0C00000}, 8'h00, "R1 R10 basic");
        send({32'h3FC00000, 32'h3F800000}, {32'h3FC00000, 32'hBF800000}, 0, 2'b00,
             {32'h40100000, 32'hBF800000}, 8'h00, "R2 back-to-back");
        // R5: halfway case, all four modes
        send({32'h3F800001, 32'hBF800001}, {32'h3FC00000, 32'h3FC00000}, 0, 2'b00,
             {32'h3FC00002, 32'hBFC00002}, {F_INX, F_INX}, "R5 nearest-even");
        send({32'h3F800001, 32'hBF800001}, {32'h3FC00000, 32'h3FC00000}, 0, 2'b01,
             {32'h3FC00001, 32'hBFC00002}, {F_INX, F_INX}, "R5 toward minus");
        send({32'h3F800001, 32'hBF800001}, {32'h3FC00000, 32'h3FC00000}, 0, 2'b10,
             {32'h3FC00002, 32'hBFC00001}, {F_INX, F_INX}, "R5 toward plus");
        send({32'h3F800001, 32'hBF800001}, {32'h3FC00000, 32'h3FC00000}, 0, 2'b11,
             {32'h3FC00001, 32'hBFC00001}, {F_INX, F_INX}, "R5 toward zero");
        // R6: overflow in all modes
        send({32'h7F000000, 32'hFF000000}, {32'h40000000, 32'h40000000}, 0, 2'b00,
             {32'h7F800000, 32'hFF800000}, {F_OVF|F_INX, F_OVF|F_INX}, "R6 nearest-even");
        send({32'h7F000000, 32'hFF000000}, {32'h40000000, 32'h40000000}, 0, 2'b01,
             {32'h7F7FFFFF, 32'hFF800000}, {F_OVF|F_INX, F_OVF|F_INX}, "R6 toward minus");
        send({32'h7F000000, 32'hFF000000}, {32'h40000000, 32'h40000000}, 0, 2'b10,
             {32'h7F800000, 32'hFF7FFFFF}, {F_OVF|F_INX, F_OVF|F_INX}, "R6 toward plus");
        send({32'h7F000000, 32'hFF000000}, {32'h40000000, 32'h40000000}, 0, 2'b11,
             {32'h7F7FFFFF, 32'hFF7FFFFF}, {F_OVF|F_INX, F_OVF|F_INX}, "R6 toward zero");
        idle(2);
        // R7: tiny products
        send({32'h00800000, 32'h80800000}, {32'h3F000000, 32'h3F000000}, 0, 2'b00,
             {32'h00000000, 32'h80000000}, {F_UNF|F_INX, F_UNF|F_INX}, "R7 tiny");
        send({32'h00800000, 32'h40000000}, {32'h3F000000, 32'h40000000}, 1, 2'b10,
             {32'h00000000, 32'h40800000}, {F_UNF|F_INX, 4'h0}, "R7 R1 tiny beside normal");
        // R8: denormal operands
        send({32'h00000001, 32'h80000001}, {32'h40000000, 32'h40000000}, 1, 2'b00,
             {32'h00000000, 32'h80000000}, 8'h00, "R8 ftz on");
        send({32'h00000001, 32'h80000001}, {32'h40000000, 32'h40000000}, 0, 2'b00,
             {32'h00000000, 32'h80000000}, {F_UNF, F_UNF}, "R8 ftz off");
        idle(1);
        // R9: NaNs and invalid
        send({32'h7FC00001, 32'h7F800001}, {32'h3F800000, 32'h3F800000}, 0, 2'b00,
             {32'h7FC00001, 32'h7FC00001}, {4'h0, F_INV}, "R9 quiet and signaling");
        send({32'h00000000, 32'h3F800000}, {32'h7F800000, 32'hFFA00000}, 0, 2'b00,
             {32'hFFC00000, 32'hFFE00000}, {F_INV, F_INV}, "R9 zero times inf");
        send({32'h7FC00005, 32'h40000000}, {32'hFFC00007, 32'h3F800000}, 0, 2'b11,
             {32'h7FC00005, 32'h40000000}, 8'h00, "R9 R1 two NaNs");
        // R10: signs of zero and infinity
        send({32'h7F800000, 32'h80000000}, {32'hC0000000, 32'h80000000}, 0, 2'b00,
             {32'hFF800000, 32'h00000000}, 8'h00, "R10 inf and zero signs");
        send({32'hFF800000, 32'h00000000}, {32'hFF800000, 32'hC0400000}, 1, 2'b01,
             {32'h7F800000, 32'h80000000}, 8'h00, "R10 neg inf and neg zero");
        // R2: long burst that wraps the tag
        for (int i = 0; i < 20; i++)
            send({32'h40000000, 32'h3F800000}, {32'h40400000, 32'h3F800000}, 0, 2'(i),
                 {32'h40C00000, 32'h3F800000}, 8'h00, "R2 burst");
        idle(10);
        check(q.size() == 0, "R3 all results returned", 64'(q.size()), 64'd0);
        finish_run();
    end
endmodule